// File: doc/BRIEF.md
# Interleaved Multiphase PWM Generator with Current Balancing

This block drives up to four buck-converter phases from one digital duty command. All phases share a single period counter. Each active phase is shifted by an equal fraction of the period, so the phases turn on in turn rather than together. For each phase, a digital current code is compared with the mean of the active phases. The duty of that phase is then trimmed: a phase that carries more than its share gets a shorter pulse, and a phase that carries less gets a longer one.

The number of phases is set at board level. A phase output that is not used is tied high, and the block senses those levels on a strap input. The strap is sampled once, in a short window after reset. During that window no output is enabled. The converter shuts down when the disable input is asserted or when the 5-bit voltage identifier is all ones. A tristate request releases the outputs without resetting the phase count.

Every input is a level that is sampled on each clock edge. No input carries a stream, so there is no valid/ready handshake and no back-pressure. A change on any input takes effect at the outputs on the next clock edge.

Top module: `mphase_pwm`

## Requirements
- R1: After reset is released, the strap is sampled at the STRAP_CYC-th clock edge. Until that edge, and for the edge that follows it, every `pwm` and `pwm_oe` bit is 0.
- R2: The phase count is decoded from the latched strap. `strap_in[3]` and `strap_in[2]` both 1 gives two phases (0 and 1). `strap_in[3]` alone gives three phases (0 to 2). Any other value gives four phases. Only the active phases can raise `pwm_oe`, and an inactive phase keeps `pwm` at 0.
- R3: With n active phases, the rising edge of phase i lags the rising edge of phase 0 by i*PERIOD/n clocks, taken modulo PERIOD.
- R4: When all active currents are equal, every active phase is high for exactly `duty_cmd` clocks in each PERIOD-clock window.
- R5: The duty of phase i is duty_cmd - ((cur_i - avg) >>> TRIM_SH), where cur_i is `cur_code[8*i +: 8]` and the shift is an arithmetic (floor) shift with a default TRIM_SH of 2. A phase with a larger current never receives a longer duty than a phase with a smaller current.
- R6: The trimmed duty saturates at 0 and at PERIOD. A saturated phase stays low, or stays high, for the whole period.
- R7: When `vid` equals 5'b11111, all `pwm` and `pwm_oe` bits are 0 from the next edge on. Any other `vid` value has no effect.
- R8: When `dis` is 1, all `pwm` and `pwm_oe` bits are 0 from the next edge on.
- R9: When `tri_req` is 1, all `pwm_oe` bits are 0 from the next edge on. Any phase whose `pwm_oe` is 0 drives `pwm` at 0.
- R10: avg is the floor of the sum of the active phases' currents divided by the active phase count. The current codes of inactive phases have no effect on any duty.
- R11: After the strap is latched, changes on `strap_in` have no effect on the phase count until the next reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Switching clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| duty_cmd | input | PER_W | Duty command in clocks per period |
| cur_code | input | 4*CUR_W | Per-phase current codes, phase i at bits [CUR_W*i +: CUR_W] |
| dis | input | 1 | Shutdown request |
| vid | input | 5 | Voltage identifier; all ones shuts the converter down |
| tri_req | input | 1 | Tristate request; releases all output enables |
| strap_in | input | 4 | Sensed levels of the phase outputs, used for phase-count strapping |
| pwm | output | 4 | Registered PWM level for each phase |
| pwm_oe | output | 4 | Registered output enable for each phase |

## Verification
The in-line properties check the following on every cycle:
- outputs stay quiet during the strap window;
- enables stay confined to the decoded active phases;
- a disabled phase holds its PWM low;
- shutdown and tristate requests take effect one edge later;
- the latched phase count stays stable;
- duties are ordered inversely to the phase currents.

The behavioural reference model in the bench is compared on every clock. Only the directed scenarios show the exact phase lags for each mode, the absolute high-time counts after trimming and saturation, and the exclusion of inactive currents from the average. They also show that late strap changes are ignored.

// File: rtl/mphase_pkg.sv
package mphase_pkg;
  localparam int MAX_PH = 4;

  typedef logic [2:0] ph_count_t;

  // Unused outputs tied high reduce the phase count.
  function automatic ph_count_t decode_strap(input logic [MAX_PH-1:0] s);
    if (s[3] && s[2]) return 3'd2;
    else if (s[3])    return 3'd3;
    else              return 3'd4;
  endfunction

  function automatic logic [MAX_PH-1:0] mask_of(input ph_count_t n);
    case (n)
      3'd2:    return 4'b0011;
      3'd3:    return 4'b0111;
      default: return 4'b1111;
    endcase
  endfunction
endpackage

// File: rtl/mphase_strap.sv
module mphase_strap
  import mphase_pkg::*;
#(
  parameter int STRAP_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MAX_PH-1:0] strap_in,
  output logic              run,
  output ph_count_t         nph,
  output logic [MAX_PH-1:0] act_mask
);
  localparam int SW = $clog2(STRAP_CYC + 1);

  logic [SW-1:0] scnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scnt <= '0;
      run  <= 1'b0;
      nph  <= 3'd4;
    end else if (!run) begin
      if (scnt == SW'(STRAP_CYC - 1)) begin
        run <= 1'b1;
        nph <= decode_strap(strap_in);
      end else begin
        scnt <= scnt + 1'b1;
      end
    end
  end

  assign act_mask = mask_of(nph);

  // The count latched at the end of the window holds until reset.
  assert_strap_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(run) |-> $stable(nph));
endmodule

// File: rtl/mphase_balance.sv
module mphase_balance
  import mphase_pkg::*;
#(
  parameter int PER_W   = 8,
  parameter int CUR_W   = 8,
  parameter int PERIOD  = 240,
  parameter int TRIM_SH = 2
) (
  input  ph_count_t               nph,
  input  logic [MAX_PH-1:0]       act_mask,
  input  logic [PER_W-1:0]        duty_cmd,
  input  logic [MAX_PH*CUR_W-1:0] cur_code,
  output logic [MAX_PH*PER_W-1:0] duty_ph
);
  localparam int SUM_W = CUR_W + 2;
  localparam int MUL_W = SUM_W + 11;
  localparam int DW    = PER_W + CUR_W + 3;
  // floor(x/3) == (x*683)>>11 holds for every x below 2045.
  localparam int RECIP3 = 683;

  logic [SUM_W-1:0] sum;
  logic [MUL_W-1:0] third;
  logic [CUR_W-1:0] avg;

  always_comb begin
    sum = '0;
    for (int i = 0; i < MAX_PH; i++) begin
      if (act_mask[i]) sum = sum + SUM_W'(cur_code[i*CUR_W +: CUR_W]);
    end
  end

  assign third = MUL_W'(sum) * MUL_W'(RECIP3);

  always_comb begin
    case (nph)
      3'd2:    avg = CUR_W'(sum >> 1);
      3'd3:    avg = CUR_W'(third >> 11);
      default: avg = CUR_W'(sum >> 2);
    endcase
  end

  for (genvar g = 0; g < MAX_PH; g++) begin : g_trim
    logic signed [DW-1:0] err, trim, dval;
    logic [PER_W-1:0]     dsat;

    assign err  = $signed(DW'(cur_code[g*CUR_W +: CUR_W])) - $signed(DW'(avg));
    assign trim = err >>> TRIM_SH;
    assign dval = $signed(DW'(duty_cmd)) - trim;

    always_comb begin
      if (dval < 0)                          dsat = '0;
      else if (dval > $signed(DW'(PERIOD)))  dsat = PER_W'(PERIOD);
      else                                   dsat = dval[PER_W-1:0];
    end

    assign duty_ph[g*PER_W +: PER_W] = dsat;
  end
endmodule

// File: rtl/mphase_carrier.sv
module mphase_carrier
  import mphase_pkg::*;
#(
  parameter int PER_W  = 8,
  parameter int PERIOD = 240
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    run,
  input  ph_count_t               nph,
  input  logic [MAX_PH*PER_W-1:0] duty_ph,
  input  logic [MAX_PH-1:0]       en,
  output logic [MAX_PH-1:0]       pwm
);
  localparam int SLOT2 = PERIOD / 2;
  localparam int SLOT3 = PERIOD / 3;
  localparam int SLOT4 = PERIOD / 4;

  logic [PER_W-1:0] cnt;
  logic [PER_W-1:0] off_a [MAX_PH];
  logic [PER_W-1:0] loc_a [MAX_PH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          cnt <= '0;
    else if (!run)                       cnt <= '0;
    else if (cnt == PER_W'(PERIOD - 1))  cnt <= '0;
    else                                 cnt <= cnt + 1'b1;
  end

  for (genvar g = 0; g < MAX_PH; g++) begin : g_slot
    assign off_a[g] = (nph == 3'd2) ? PER_W'((g * SLOT2) % PERIOD) :
                      (nph == 3'd3) ? PER_W'((g * SLOT3) % PERIOD) :
                                      PER_W'((g * SLOT4) % PERIOD);
    // Wraps modulo 2^PER_W; the result always lies below PERIOD.
    assign loc_a[g] = (cnt >= off_a[g]) ? cnt - off_a[g]
                                        : cnt + PER_W'(PERIOD) - off_a[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwm <= '0;
    end else begin
      for (int i = 0; i < MAX_PH; i++)
        pwm[i] <= en[i] && (loc_a[i] < duty_ph[i*PER_W +: PER_W]);
    end
  end

  // The shared carrier never leaves the period range.
  assert_cnt_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < PER_W'(PERIOD));
endmodule

// File: rtl/mphase_pwm.sv
module mphase_pwm
  import mphase_pkg::*;
#(
  parameter int PERIOD    = 240,
  parameter int CUR_W     = 8,
  parameter int TRIM_SH   = 2,
  parameter int STRAP_CYC = 4,
  localparam int PER_W    = $clog2(PERIOD + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [PER_W-1:0]        duty_cmd,
  input  logic [MAX_PH*CUR_W-1:0] cur_code,
  input  logic                    dis,
  input  logic [4:0]              vid,
  input  logic                    tri_req,
  input  logic [MAX_PH-1:0]       strap_in,
  output logic [MAX_PH-1:0]       pwm,
  output logic [MAX_PH-1:0]       pwm_oe
);
  logic                    run;
  ph_count_t               nph;
  logic [MAX_PH-1:0]       act_mask;
  logic [MAX_PH*PER_W-1:0] duty_ph;
  logic                    shutdown;
  logic [MAX_PH-1:0]       en;

  mphase_strap #(.STRAP_CYC(STRAP_CYC)) u_strap (
    .clk(clk), .rst_n(rst_n), .strap_in(strap_in),
    .run(run), .nph(nph), .act_mask(act_mask)
  );

  mphase_balance #(.PER_W(PER_W), .CUR_W(CUR_W), .PERIOD(PERIOD), .TRIM_SH(TRIM_SH)) u_bal (
    .nph(nph), .act_mask(act_mask), .duty_cmd(duty_cmd),
    .cur_code(cur_code), .duty_ph(duty_ph)
  );

  assign shutdown = dis | (&vid);
  assign en       = act_mask & {MAX_PH{run & ~shutdown & ~tri_req}};

  mphase_carrier #(.PER_W(PER_W), .PERIOD(PERIOD)) u_car (
    .clk(clk), .rst_n(rst_n), .run(run), .nph(nph),
    .duty_ph(duty_ph), .en(en), .pwm(pwm)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pwm_oe <= '0;
    else        pwm_oe <= en;
  end

  assert_quiet_strap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (pwm_oe == '0) && (pwm == '0));

  assert_active_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_oe & ~act_mask) == '0);

  assert_vid_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (&vid) |=> (pwm_oe == '0) && (pwm == '0));

  assert_dis_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dis |=> (pwm_oe == '0) && (pwm == '0));

  assert_tri_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tri_req |=> (pwm_oe == '0));

  for (genvar a = 0; a < MAX_PH; a++) begin : g_chk
    assert_oe_gates_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !pwm_oe[a] |-> !pwm[a]);
    for (genvar b = 0; b < MAX_PH; b++) begin : g_pair
      if (a != b) begin : g_ne
        // A hotter phase never receives the longer pulse.
        assert_trim_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
          (act_mask[a] && act_mask[b] &&
           (cur_code[a*CUR_W +: CUR_W] > cur_code[b*CUR_W +: CUR_W]))
          |-> (duty_ph[a*PER_W +: PER_W] <= duty_ph[b*PER_W +: PER_W]));
      end
    end
  end
endmodule

// File: tb/mphase_pwm_tb.sv
`timescale 1ns/1ps
module mphase_pwm_tb;
  localparam int P  = 240;
  localparam int S  = 4;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [7:0]    duty_cmd;
  logic [31:0]   cur_code;
  logic          dis, tri_req;
  logic [4:0]    vid;
  logic [3:0]    strap_in;
  logic [3:0]    pwm, pwm_oe;

  int n_chk = 0, n_err = 0;
  int cyc = 0;
  int rise [4];
  logic [3:0] prv = '0;

  // Reference model state
  int   m_scnt, m_cnt, m_n;
  bit   m_run;
  logic [3:0] e_pwm = '0, e_oe = '0;

  always #5 clk = ~clk;

  mphase_pwm #(.PERIOD(P), .CUR_W(CW), .TRIM_SH(2), .STRAP_CYC(S)) u_dut (
    .clk(clk), .rst_n(rst_n), .duty_cmd(duty_cmd), .cur_code(cur_code),
    .dis(dis), .vid(vid), .tri_req(tri_req), .strap_in(strap_in),
    .pwm(pwm), .pwm_oe(pwm_oe)
  );

  function automatic int cur_of(int i);
    return int'(cur_code[i*CW +: CW]);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_scnt = 0; m_cnt = 0; m_n = 4; m_run = 0;
      e_pwm = '0; e_oe = '0;
    end else if (m_run) begin
      int sum, avg, off, loc, err, tr, d;
      bit go;
      go  = !dis && (vid != 5'h1f) && !tri_req;
      sum = 0;
      for (int i = 0; i < m_n; i++) sum += cur_of(i);
      avg = sum / m_n;
      for (int i = 0; i < 4; i++) begin
        off = (i * P / m_n) % P;
        loc = (m_cnt - off + P) % P;
        err = cur_of(i) - avg;
        tr  = err >>> 2;
        d   = int'(duty_cmd) - tr;
        if (d < 0) d = 0;
        if (d > P) d = P;
        e_oe[i]  = go && (i < m_n);
        e_pwm[i] = e_oe[i] && (loc < d);
      end
      m_cnt = (m_cnt + 1) % P;
    end else begin
      e_pwm = '0; e_oe = '0;
      if (m_scnt == S - 1) begin
        m_run = 1;
        if (strap_in[3] && strap_in[2]) m_n = 2;
        else if (strap_in[3])           m_n = 3;
        else                            m_n = 4;
      end else begin
        m_scnt++;
      end
    end
  end

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Cycle-by-cycle model comparison (covers R4 R5 R6 R10 timing)
  always @(negedge clk) begin
    cyc++;
    n_chk++;
    if (pwm !== e_pwm || pwm_oe !== e_oe) begin
      n_err++;
      $display("FAIL R4 model compare cyc=%0d actual=%h/%h expected=%h/%h",
               cyc, pwm, pwm_oe, e_pwm, e_oe);
    end
    for (int i = 0; i < 4; i++) if (pwm[i] && !prv[i]) rise[i] = cyc;
    prv = pwm;
  end

  always @(posedge clk) begin
    if (cyc > 150000) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic count_high(int i, output int c);
    c = 0;
    repeat (P) begin
      @(negedge clk);
      c += int'(pwm[i]);
    end
    #1;
  endtask

  task automatic gap_check(string tag, int k, int exp);
    idle(2 * P);
    check(tag, (((rise[k] - rise[0]) % P) + P) % P, exp);
  endtask

  task automatic set_cur(int c0, int c1, int c2, int c3);
    cur_code = {c3[7:0], c2[7:0], c1[7:0], c0[7:0]};
  endtask

  task automatic do_reset(logic [3:0] strap);
    @(negedge clk); #1;
    rst_n = 1'b0;
    strap_in = strap;
    idle(3);
    rst_n = 1'b1;
    for (int k = 0; k < S; k++) begin
      @(negedge clk);
      check("R1 quiet pwm", int'(pwm), 0);
      check("R1 quiet oe", int'(pwm_oe), 0);
    end
    #1;
    idle(P);
  endtask

  initial begin
    int c;
    rst_n = 1'b0; duty_cmd = 8'd60; dis = 0; vid = 5'd0; tri_req = 0;
    strap_in = 4'b0000; set_cur(80, 80, 80, 80);

    // Four phases
    do_reset(4'b0000);
    check("R2 four-phase oe", int'(pwm_oe), 15);
    count_high(0, c); check("R4 phase0 high", c, 60);
    count_high(2, c); check("R4 phase2 high", c, 60);
    gap_check("R3 lag phase1", 1, 60);
    gap_check("R3 lag phase2", 2, 120);
    gap_check("R3 lag phase3", 3, 180);

    // Trim: avg 70
    set_cur(100, 60, 60, 60); idle(P);
    count_high(0, c); check("R5 hot phase narrowed", c, 53);
    count_high(1, c); check("R5 cool phase widened", c, 63);

    // Saturation
    duty_cmd = 8'd250; set_cur(80, 80, 80, 80); idle(P);
    count_high(1, c); check("R6 saturate full", c, 240);
    duty_cmd = 8'd2; set_cur(200, 0, 0, 0); idle(P);
    count_high(0, c); check("R6 saturate zero", c, 0);
    count_high(1, c); check("R6 low-side widened", c, 15);
    duty_cmd = 8'd60; set_cur(80, 80, 80, 80); idle(P);

    // Shutdown and release
    vid = 5'h1f; idle(3);
    check("R7 vid off oe", int'(pwm_oe), 0);
    count_high(0, c); check("R7 vid off pwm", c, 0);
    vid = 5'h1e; idle(3);
    check("R7 other vid on", int'(pwm_oe), 15);
    vid = 5'h00;
    dis = 1'b1; idle(3);
    check("R8 dis oe", int'(pwm_oe), 0);
    count_high(1, c); check("R8 dis pwm", c, 0);
    dis = 1'b0;
    tri_req = 1'b1; idle(3);
    check("R9 tri oe", int'(pwm_oe), 0);
    count_high(2, c); check("R9 tri pwm", c, 0);
    tri_req = 1'b0; idle(3);
    check("R9 tri released", int'(pwm_oe), 15);

    // Three phases
    do_reset(4'b1000);
    check("R2 three-phase oe", int'(pwm_oe), 7);
    gap_check("R3 lag3 phase1", 1, 80);
    gap_check("R3 lag3 phase2", 2, 160);
    set_cur(90, 60, 60, 255); idle(P);
    count_high(0, c); check("R10 avg of active phase0", c, 55);
    count_high(1, c); check("R10 avg of active phase1", c, 63);
    set_cur(90, 60, 60, 0); idle(P);
    count_high(0, c); check("R10 inactive current ignored", c, 55);
    count_high(3, c); check("R2 inactive phase low", c, 0);
    strap_in = 4'b0000; idle(P);
    check("R11 strap held oe", int'(pwm_oe), 7);
    gap_check("R11 strap held lag", 1, 80);

    // Two phases
    set_cur(80, 80, 80, 80);
    do_reset(4'b1100);
    check("R2 two-phase oe", int'(pwm_oe), 3);
    gap_check("R3 lag2 phase1", 1, 120);
    count_high(0, c); check("R4 two-phase high", c, 60);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule